// File: doc/BRIEF.md
# Overvoltage/Undervoltage Channel Scan Sequencer

This block shares one overvoltage comparator and one undervoltage comparator pair across a set of cell-voltage input channels. It drives the select of the analog multiplexer in front of the comparators, waits for each channel to settle, samples the comparator outputs and keeps sticky fault flags for every channel. The undervoltage side carries two comparators, one against the undervoltage threshold and one against a balancing-done threshold. Each active channel therefore yields an undervoltage bit and a balancing-done bit next to its overvoltage bit.

A controller picks one of four modes and starts it with a go strobe. Round-robin scan loops through every channel forever. The period is the same whatever the active mask is, because inactive channels are still visited and only their results are dropped. Single-channel lock parks the multiplexer on one channel, for checking the threshold DACs. Self-test steps through all channels once without recording anything, then pulses a done output. Stop halts the scan. The thresholds and the comparators are outside the block, and their outputs arrive as inputs.

Top module: `ovuv_scan_seq`

## Requirements
- R1: After reset busy_o and bist_done_o are 0, mux_sel_o is 0 and all three flag vectors are 0.
- R2: mode_i (00 stop, 01 round-robin scan, 10 self-test, 11 single-channel lock) takes effect only in the cycle go_i is high. Changing mode_i or lock_ch_i without go_i does not start, stop or alter a run.
- R3: In scan mode mux_sel_o starts at 0 in the cycle after go and holds each channel for SLOT_CYC cycles, in ascending order. It wraps from NUM_CH-1 to 0, so one round is NUM_CH*SLOT_CYC cycles for any active mask.
- R4: The comparators are sampled in the last cycle of a slot. The flags of channel k first show a fault SLOT_CYC*(k+1) cycles after the go edge.
- R5: A channel whose active_mask_i bit is 0 at its sample cycle never sets any of its flags.
- R6: For each active channel the overvoltage, undervoltage and balancing-done results are recorded independently in ov_flag_o, uv_flag_o and bd_flag_o, at bit position equal to the channel number.
- R7: In lock mode mux_sel_o stays at the lock_ch_i value captured at go, and only that channel can set flags.
- R8: A go with mode 00 drops busy_o in the next cycle and returns mux_sel_o to 0. While stopped, no flag is set whatever the comparators show.
- R9: A self-test run sets no flag. It raises bist_done_o for exactly one cycle, NUM_CH*SLOT_CYC cycles after the go edge, and busy_o falls in that same cycle.
- R10: Flags are sticky: once set, they stay set until flag_clr_i is high for a cycle, which clears all of them. A clear wins over a same-cycle set.
- R11: busy_o is high in every cycle in which a scan, lock or self-test run is executing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_i | input | 2 | Mode request, captured on go |
| go_i | input | 1 | Start strobe; applies mode_i |
| lock_ch_i | input | CH_W | Channel for lock mode, captured on go |
| active_mask_i | input | NUM_CH | Per-channel enable of result recording |
| ov_cmp_i | input | 1 | Overvoltage comparator output |
| uv_cmp_i | input | 1 | Undervoltage comparator output |
| bd_cmp_i | input | 1 | Balancing-done comparator output |
| flag_clr_i | input | 1 | Clears all fault flags |
| mux_sel_o | output | CH_W | Comparator multiplexer channel select |
| ov_flag_o | output | NUM_CH | Sticky overvoltage flags |
| uv_flag_o | output | NUM_CH | Sticky undervoltage flags |
| bd_flag_o | output | NUM_CH | Sticky balancing-done flags |
| busy_o | output | 1 | A non-stop mode is executing |
| bist_done_o | output | 1 | One-cycle self-test completion pulse |

## Verification
The bench models the comparators as a per-channel pattern indexed by mux_sel_o. A design that sampled the wrong slot or let the mux drift would set flags on the wrong bits. It checks the wrap from the last channel to 0 at exactly one round with a sparse mask and with an empty mask. A design that skipped inactive channels would wrap early. It changes mode_i and lock_ch_i in the middle of a run, which catches a design that reads these fields live instead of latching them. It times the self-test done pulse to the cycle, and it checks that a stopped sequencer and a self-test run leave the flags untouched even while every comparator reads high.

// File: rtl/ovuv_scan_pkg.sv
package ovuv_scan_pkg;

  typedef enum logic [1:0] {
    MODE_STOP = 2'b00,
    MODE_SCAN = 2'b01,
    MODE_BIST = 2'b10,
    MODE_LOCK = 2'b11
  } mode_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SCAN,
    ST_BIST,
    ST_LOCK
  } state_e;

  // Run state selected by a mode request at go time
  function automatic state_e mode_to_state(input logic [1:0] m);
    case (m)
      MODE_SCAN: mode_to_state = ST_SCAN;
      MODE_BIST: mode_to_state = ST_BIST;
      MODE_LOCK: mode_to_state = ST_LOCK;
      default:   mode_to_state = ST_IDLE;
    endcase
  endfunction

  // States in which comparator results are written to the flags
  function automatic logic state_records(input state_e s);
    state_records = (s == ST_SCAN) || (s == ST_LOCK);
  endfunction

  // States in which the channel index advances at each slot end
  function automatic logic state_steps(input state_e s);
    state_steps = (s == ST_SCAN) || (s == ST_BIST);
  endfunction

endpackage

// File: rtl/ovuv_slot_timer.sv
module ovuv_slot_timer #(
  parameter int SLOT_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic restart_i,
  output logic slot_end_o
);
  localparam int CW = (SLOT_CYC > 1) ? $clog2(SLOT_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(SLOT_CYC - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (!run_i || restart_i || cnt_q == LAST)
      cnt_q <= '0;
    else
      cnt_q <= cnt_q + 1'b1;
  end

  assign slot_end_o = run_i && !restart_i && (cnt_q == LAST);

  generate
    if (SLOT_CYC > 1) begin : g_gap
      AST_SLOT_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        slot_end_o |=> !slot_end_o); // R3
    end
  endgenerate

endmodule

// File: rtl/ovuv_chan_stepper.sv
module ovuv_chan_stepper #(
  parameter int NUM_CH = 16,
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load_i,
  input  logic [CH_W-1:0] load_val_i,
  input  logic            adv_i,
  output logic [CH_W-1:0] idx_o,
  output logic            at_last_o
);
  localparam logic [CH_W-1:0] LAST_CH = CH_W'(NUM_CH - 1);

  function automatic logic [CH_W-1:0] next_idx(input logic [CH_W-1:0] cur);
    next_idx = (cur == LAST_CH) ? '0 : cur + 1'b1;
  endfunction

  logic [CH_W-1:0] idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      idx_q <= '0;
    else if (load_i)
      idx_q <= load_val_i;
    else if (adv_i)
      idx_q <= next_idx(idx_q);
  end

  assign idx_o     = idx_q;
  assign at_last_o = (idx_q == LAST_CH);

  AST_STEP_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_i && !load_i && at_last_o) |=> (idx_o == '0)); // R3

endmodule

// File: rtl/ovuv_fault_bank.sv
module ovuv_fault_bank #(
  parameter int NUM_CH = 16,
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rec_i,
  input  logic [CH_W-1:0]   ch_i,
  input  logic [NUM_CH-1:0] act_i,
  input  logic              ov_i,
  input  logic              uv_i,
  input  logic              bd_i,
  input  logic              clr_i,
  output logic [NUM_CH-1:0] ov_q_o,
  output logic [NUM_CH-1:0] uv_q_o,
  output logic [NUM_CH-1:0] bd_q_o
);

  logic [NUM_CH-1:0] hit;

  generate
    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      assign hit[i] = rec_i && (ch_i == CH_W'(i)) && act_i[i];

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          ov_q_o[i] <= 1'b0;
          uv_q_o[i] <= 1'b0;
          bd_q_o[i] <= 1'b0;
        end else if (clr_i) begin
          ov_q_o[i] <= 1'b0;
          uv_q_o[i] <= 1'b0;
          bd_q_o[i] <= 1'b0;
        end else if (hit[i]) begin
          ov_q_o[i] <= ov_q_o[i] | ov_i;
          uv_q_o[i] <= uv_q_o[i] | uv_i;
          bd_q_o[i] <= bd_q_o[i] | bd_i;
        end
      end

      AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!hit[i] && !clr_i) |=> ($stable(ov_q_o[i]) && $stable(uv_q_o[i]) && $stable(bd_q_o[i]))); // R5
    end
  endgenerate

  AST_HIT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit)); // R6

  AST_CLR_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (ov_q_o == '0 && uv_q_o == '0 && bd_q_o == '0)); // R10

endmodule

// File: rtl/ovuv_scan_seq.sv
module ovuv_scan_seq
  import ovuv_scan_pkg::*;
#(
  parameter int NUM_CH   = 16,
  parameter int SLOT_CYC = 4,
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode_i,
  input  logic              go_i,
  input  logic [CH_W-1:0]   lock_ch_i,
  input  logic [NUM_CH-1:0] active_mask_i,
  input  logic              ov_cmp_i,
  input  logic              uv_cmp_i,
  input  logic              bd_cmp_i,
  input  logic              flag_clr_i,
  output logic [CH_W-1:0]   mux_sel_o,
  output logic [NUM_CH-1:0] ov_flag_o,
  output logic [NUM_CH-1:0] uv_flag_o,
  output logic [NUM_CH-1:0] bd_flag_o,
  output logic              busy_o,
  output logic              bist_done_o
);
  localparam logic [CH_W-1:0] LAST_CH = CH_W'(NUM_CH - 1);

  state_e state_q, state_d;
  logic   bist_done_q;

  // Named internal events
  logic            run;
  logic            slot_end;
  logic            step_adv;
  logic            rec_evt;
  logic            at_last;
  logic            bist_fin;
  logic [CH_W-1:0] start_ch;
  logic [CH_W-1:0] ch_idx;

  assign run      = (state_q != ST_IDLE);
  assign step_adv = slot_end && state_steps(state_q);
  assign rec_evt  = slot_end && state_records(state_q);
  assign bist_fin = slot_end && (state_q == ST_BIST) && at_last && !go_i;
  assign start_ch = (mode_i == MODE_LOCK) ? lock_ch_i : '0;

  always_comb begin
    state_d = state_q;
    if (go_i)
      state_d = mode_to_state(mode_i);
    else if (bist_fin)
      state_d = ST_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      bist_done_q <= 1'b0;
    end else begin
      state_q     <= state_d;
      bist_done_q <= bist_fin;
    end
  end

  ovuv_slot_timer #(.SLOT_CYC(SLOT_CYC)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .run_i      (run),
    .restart_i  (go_i),
    .slot_end_o (slot_end)
  );

  ovuv_chan_stepper #(.NUM_CH(NUM_CH)) u_stepper (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (go_i),
    .load_val_i (start_ch),
    .adv_i      (step_adv),
    .idx_o      (ch_idx),
    .at_last_o  (at_last)
  );

  ovuv_fault_bank #(.NUM_CH(NUM_CH)) u_faults (
    .clk    (clk),
    .rst_n  (rst_n),
    .rec_i  (rec_evt),
    .ch_i   (ch_idx),
    .act_i  (active_mask_i),
    .ov_i   (ov_cmp_i),
    .uv_i   (uv_cmp_i),
    .bd_i   (bd_cmp_i),
    .clr_i  (flag_clr_i),
    .ov_q_o (ov_flag_o),
    .uv_q_o (uv_flag_o),
    .bd_q_o (bd_flag_o)
  );

  assign mux_sel_o   = ch_idx;
  assign busy_o      = run;
  assign bist_done_o = bist_done_q;

  AST_SCAN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SCAN && slot_end && !go_i) |=>
      (mux_sel_o == (($past(mux_sel_o) == LAST_CH) ? '0 : CH_W'($past(mux_sel_o) + 1'b1)))); // R3

  AST_SCAN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SCAN && !slot_end && !go_i) |=> $stable(mux_sel_o)); // R3

  AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_LOCK && !go_i) |=> $stable(mux_sel_o)); // R7

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    bist_done_o |-> !busy_o); // R9

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    bist_done_o |=> !bist_done_o); // R9

  AST_STOP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !flag_clr_i) |=> ($stable(ov_flag_o) && $stable(uv_flag_o) && $stable(bd_flag_o))); // R8

  AST_BIST_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_BIST && !flag_clr_i) |=> ($stable(ov_flag_o) && $stable(uv_flag_o) && $stable(bd_flag_o))); // R9

  AST_STOP_GO: assert property (@(posedge clk) disable iff (!rst_n)
    (go_i && mode_i == MODE_STOP) |=> (!busy_o && mux_sel_o == '0)); // R8

  AST_RUN_GO: assert property (@(posedge clk) disable iff (!rst_n)
    (go_i && mode_i != MODE_STOP) |=> busy_o); // R11

endmodule

// File: tb/ovuv_scan_seq_bench.sv
module ovuv_scan_seq_bench;
  localparam int N  = 16;
  localparam int S  = 4;
  localparam int CW = 4;
  localparam int ROUND = N * S;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    mode_i = 2'b00;
  logic          go_i = 1'b0;
  logic [CW-1:0] lock_ch_i = '0;
  logic [N-1:0]  active_mask_i = '1;
  logic          flag_clr_i = 1'b0;
  logic [N-1:0]  ov_pat = '0, uv_pat = '0, bd_pat = '0;
  logic          ov_cmp, uv_cmp, bd_cmp;
  logic [CW-1:0] mux_sel_o;
  logic [N-1:0]  ov_flag_o, uv_flag_o, bd_flag_o;
  logic          busy_o, bist_done_o;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  // Comparator model: the selected channel's pattern bit
  assign ov_cmp = ov_pat[mux_sel_o];
  assign uv_cmp = uv_pat[mux_sel_o];
  assign bd_cmp = bd_pat[mux_sel_o];

  ovuv_scan_seq #(.NUM_CH(N), .SLOT_CYC(S)) u_ovuv_scan_seq (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .go_i(go_i),
    .lock_ch_i(lock_ch_i), .active_mask_i(active_mask_i),
    .ov_cmp_i(ov_cmp), .uv_cmp_i(uv_cmp), .bd_cmp_i(bd_cmp),
    .flag_clr_i(flag_clr_i), .mux_sel_o(mux_sel_o),
    .ov_flag_o(ov_flag_o), .uv_flag_o(uv_flag_o), .bd_flag_o(bd_flag_o),
    .busy_o(busy_o), .bist_done_o(bist_done_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic go_mode(input logic [1:0] m);
    @(negedge clk); mode_i = m; go_i = 1'b1;
    @(negedge clk); go_i = 1'b0;
  endtask

  task automatic clear_flags();
    @(negedge clk); flag_clr_i = 1'b1;
    @(negedge clk); flag_clr_i = 1'b0;
  endtask

  function automatic int exp_sel(input int j);
    return (j / S) % N;
  endfunction

  task automatic t_reset();
    chk("R1 busy", 32'(busy_o), 0);
    chk("R1 done", 32'(bist_done_o), 0);
    chk("R1 mux", 32'(mux_sel_o), 0);
    chk("R1 flags", 32'(ov_flag_o | uv_flag_o | bd_flag_o), 0);
  endtask

  task automatic t_no_go();
    ov_pat = '1; uv_pat = '1; bd_pat = '1;
    @(negedge clk); mode_i = 2'b01;
    repeat (ROUND + 8) @(negedge clk);
    chk("R2 no go busy", 32'(busy_o), 0);
    chk("R2 no go flags", 32'(ov_flag_o | uv_flag_o | bd_flag_o), 0);
  endtask

  task automatic t_scan();
    int sel_err = 0;
    ov_pat = 16'h0008; uv_pat = 16'h0120; bd_pat = 16'h8001;
    active_mask_i = '1;
    go_mode(2'b01);
    for (int j = 0; j < ROUND; j++) begin
      if (32'(mux_sel_o) != 32'(exp_sel(j))) sel_err++;
      if (j == 5) mode_i = 2'b10;
      if (j == 15) chk("R4 ch3 before sample", 32'(ov_flag_o[3]), 0);
      if (j == 16) chk("R4 ch3 at sample", 32'(ov_flag_o[3]), 1);
      @(negedge clk);
    end
    chk("R3 scan order", 32'(sel_err), 0);
    chk("R2 mode change ignored busy", 32'(busy_o), 1);
    chk("R11 busy scan", 32'(busy_o), 1);
    chk("R6 ov flags", 32'(ov_flag_o), 32'h0008);
    chk("R6 uv flags", 32'(uv_flag_o), 32'h0120);
    chk("R6 bd flags", 32'(bd_flag_o), 32'h8001);
    go_mode(2'b00);
    chk("R8 busy after stop", 32'(busy_o), 0);
    chk("R8 mux after stop", 32'(mux_sel_o), 0);
    ov_pat = '1; uv_pat = '1; bd_pat = '1;
    repeat (ROUND + 8) @(negedge clk);
    chk("R8 ov held", 32'(ov_flag_o), 32'h0008);
    chk("R8 uv held", 32'(uv_flag_o), 32'h0120);
  endtask

  task automatic t_mask(input logic [N-1:0] m);
    clear_flags();
    ov_pat = '1; uv_pat = '1; bd_pat = '1;
    active_mask_i = m;
    go_mode(2'b01);
    for (int j = 0; j <= ROUND; j++) begin
      if (j == ROUND - 1) chk("R3 last slot", 32'(mux_sel_o), N - 1);
      if (j == ROUND) chk("R3 wrap period", 32'(mux_sel_o), 0);
      if (j < ROUND) @(negedge clk);
    end
    chk("R5 ov masked", 32'(ov_flag_o), 32'(m));
    chk("R5 bd masked", 32'(bd_flag_o), 32'(m));
    go_mode(2'b00);
    active_mask_i = '1;
  endtask

  task automatic t_lock();
    int sel_err = 0;
    clear_flags();
    ov_pat = '1; uv_pat = '1; bd_pat = '1;
    active_mask_i = '1;
    @(negedge clk); lock_ch_i = 4'd9; mode_i = 2'b11; go_i = 1'b1;
    @(negedge clk); go_i = 1'b0; lock_ch_i = 4'd2;
    for (int j = 0; j < 40; j++) begin
      if (mux_sel_o != 4'd9) sel_err++;
      @(negedge clk);
    end
    chk("R7 lock mux", 32'(sel_err), 0);
    chk("R11 busy lock", 32'(busy_o), 1);
    chk("R7 lock ov", 32'(ov_flag_o), 32'h0200);
    chk("R7 lock uv", 32'(uv_flag_o), 32'h0200);
    go_mode(2'b00);
  endtask

  task automatic t_bist();
    clear_flags();
    ov_pat = '1; uv_pat = '1; bd_pat = '1;
    go_mode(2'b10);
    for (int j = 0; j <= ROUND + 1; j++) begin
      if (j == 1) chk("R11 busy bist", 32'(busy_o), 1);
      if (j == ROUND - 1) chk("R9 done early", 32'({bist_done_o, busy_o}), 32'b01);
      if (j == ROUND) chk("R9 done pulse", 32'({bist_done_o, busy_o}), 32'b10);
      if (j == ROUND + 1) chk("R9 done single", 32'({bist_done_o, busy_o}), 32'b00);
      if (j <= ROUND) @(negedge clk);
    end
    chk("R9 no flags", 32'(ov_flag_o | uv_flag_o | bd_flag_o), 0);
  endtask

  task automatic t_sticky();
    clear_flags();
    ov_pat = '1; uv_pat = '0; bd_pat = '0;
    go_mode(2'b01);
    repeat (ROUND) @(negedge clk);
    ov_pat = '0;
    repeat (ROUND) @(negedge clk);
    chk("R10 sticky ov", 32'(ov_flag_o), 32'hFFFF);
    go_mode(2'b00);
    clear_flags();
    chk("R10 cleared", 32'(ov_flag_o | uv_flag_o | bd_flag_o), 0);
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_no_go();
    t_scan();
    t_mask(16'hA5C3);
    t_mask(16'h0000);
    t_lock();
    t_bist();
    t_sticky();
    finished = 1;
    report();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
      $finish;
    end
  end

endmodule